// File: doc/BRIEF.md
# Read-Advance RAW Hazard Evaluator

This block works out, for one source operand of an instruction waiting to issue, how many cycles must still pass before the operand's value can be consumed. It is given a short list of producer entries that may feed the operand. Each entry describes a writer that is either still in flight or has already written back. Each entry also carries a signed read-advance value: a positive value means the consumer can pick the result up early, and a negative value means it needs the result for extra cycles after write-back.

An in-flight writer contributes its remaining latency reduced by the read-advance. A writer that has already written back still blocks the read while the cycles since its write-back are fewer than the magnitude of a negative read-advance. The block reports the largest remaining-cycle count and the register of the producer that causes it. If no known hazard exists but some in-flight writer has an unknown latency, it reports an unknown hazard. The entries are evaluated combinationally, and the result is registered, so it appears one clock after the inputs.

Top module: `readHazardEval`

## Requirements
- R1: After reset, and until the first clock edge after reset is released, hazValid, hazUnknown, hazCycles and hazReg are all zero.
- R2: An in-flight entry with known latency yields cyclesLeft minus readAdv, where readAdv is two's complement over ADV_W bits. It counts as a hazard only when this result is greater than zero.
- R3: A completed entry (inFlight bit 0) counts only when readAdv is negative and elapsed is below -readAdv. Here elapsed is curCycle minus wbCycle, taken modulo 2^CYC_W. The entry then yields -readAdv minus elapsed.
- R4: When at least one hazard counts, hazValid=1, hazUnknown=0, and hazCycles is the largest yielded value. hazReg is the regId of the first entry holding that value, taking in-flight entries by ascending index before completed entries by ascending index.
- R5: When no hazard counts but some valid in-flight entry has latUnknown=1, hazValid=1, hazUnknown=1 and hazCycles=0. hazReg is the regId of the lowest-index such entry. A counted known hazard from any entry overrides unknown latency.
- R6: When nothing counts and no unknown entry exists, hazValid=0, hazUnknown=0, hazCycles=0 and hazReg=0.
- R7: An entry whose prodId equals the prodId of a lower-index valid entry is treated as the same producer and ignored.
- R8: An entry with entValid bit 0 has no effect on the result.
- R9: The outputs change only at a rising clock edge. They reflect the inputs present just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| curCycle | input | CYC_W | Current cycle counter |
| entValid | input | N | Entry i is present |
| inFlight | input | N | 1: writer still executing, 0: written back |
| latUnknown | input | N | Latency of an in-flight writer not yet known |
| cyclesLeft | input | N*CYC_W | Remaining latency per entry, unsigned |
| wbCycle | input | N*CYC_W | Write-back cycle per entry |
| readAdv | input | N*ADV_W | Signed read-advance per entry |
| regId | input | N*REG_W | Register written by the entry |
| prodId | input | N*PID_W | Producer identity, used for merging duplicates |
| hazValid | output | 1 | A hazard (known or unknown) is reported |
| hazUnknown | output | 1 | The reported hazard has unknown length |
| hazCycles | output | CYC_W+1 | Worst-case remaining cycles |
| hazReg | output | REG_W | Register responsible for the hazard |

## Verification
Every result lands exactly one rising edge after the entry list is applied. The bench applies entries at a falling edge and compares the outputs at the next falling edge, after the one registering edge. For R9 it also changes the inputs and samples shortly afterwards, before any rising edge, to confirm the previous result is still held. Directed cases cover the boundaries: a zero or negative in-flight result, elapsed equal to the advance magnitude, counter wrap, ties between in-flight and completed entries, unknown latency with and without known hazards, duplicates and invalid entries. Seeded random entry lists are then compared against a bench reference model.

// File: rtl/hazEvalPkg.sv
package hazEvalPkg;
  localparam int SEL_W = 4;

  typedef struct packed {
    logic             loadKnown;
    logic             loadUnknown;
    logic             loadNone;
    logic [SEL_W-1:0] selIdx;
  } hazStrobe_t;
endpackage

// File: rtl/hazDatapath.sv
module hazDatapath
  import hazEvalPkg::*;
#(
  parameter int N     = 4,
  parameter int CYC_W = 8,
  parameter int ADV_W = 4,
  parameter int REG_W = 6,
  parameter int PID_W = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [CYC_W-1:0]       curCycle,
  input  logic [N-1:0]           entValid,
  input  logic [N-1:0]           inFlight,
  input  logic [N-1:0]           latUnknown,
  input  logic [N*CYC_W-1:0]     cyclesLeft,
  input  logic [N*CYC_W-1:0]     wbCycle,
  input  logic [N*ADV_W-1:0]     readAdv,
  input  logic [N*REG_W-1:0]     regId,
  input  logic [N*PID_W-1:0]     prodId,
  input  hazStrobe_t             strobe,
  output logic [N-1:0]           knownCand,
  output logic [N-1:0]           unkCand,
  output logic [N*(CYC_W+1)-1:0] remFlat,
  output logic                   hazValid,
  output logic                   hazUnknown,
  output logic [CYC_W:0]         hazCycles,
  output logic [REG_W-1:0]       hazReg
);
  localparam int REM_W = CYC_W + 1;
  localparam int WIDE_W = CYC_W + 2;
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  for (genvar i = 0; i < N; i++) begin : g_entry
    logic [CYC_W-1:0]        cl;
    logic [CYC_W-1:0]        wb;
    logic [ADV_W-1:0]        adv;
    logic [PID_W-1:0]        pid;
    logic signed [WIDE_W-1:0] flightRem;
    logic [CYC_W-1:0]        elapsed;
    logic [CYC_W-1:0]        negAdvWide;
    logic                    compQual;
    logic [CYC_W-1:0]        compRem;
    logic                    dup;
    logic                    live;

    assign cl  = cyclesLeft[i*CYC_W +: CYC_W];
    assign wb  = wbCycle[i*CYC_W +: CYC_W];
    assign adv = readAdv[i*ADV_W +: ADV_W];
    assign pid = prodId[i*PID_W +: PID_W];

    assign flightRem = $signed({2'b00, cl}) -
                       $signed({{(WIDE_W-ADV_W){adv[ADV_W-1]}}, adv});
    assign elapsed    = curCycle - wb;
    assign negAdvWide = {CYC_W{1'b0}} - {{(CYC_W-ADV_W){adv[ADV_W-1]}}, adv};
    assign compQual   = adv[ADV_W-1] && (elapsed < negAdvWide);
    assign compRem    = negAdvWide - elapsed;

    always_comb begin
      dup = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (entValid[j] && (prodId[j*PID_W +: PID_W] == pid)) dup = 1'b1;
      end
    end

    assign live = entValid[i] && !dup;
    assign knownCand[i] = live && (inFlight[i] ? (!latUnknown[i] && (flightRem > 0))
                                               : compQual);
    assign unkCand[i] = live && inFlight[i] && latUnknown[i];
    assign remFlat[i*REM_W +: REM_W] = inFlight[i] ? flightRem[REM_W-1:0]
                                                   : {1'b0, compRem};

    // R3: a completed writer never blocks longer than its advance magnitude
    p_completed_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
      (knownCand[i] && !inFlight[i]) |->
        (remFlat[i*REM_W +: REM_W] <= {1'b0, negAdvWide}));
    // R8: an absent entry produces no candidate
    p_invalid_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
      !entValid[i] |-> (!knownCand[i] && !unkCand[i]));
  end

  logic [IDX_W-1:0] sel;
  assign sel = strobe.selIdx[IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hazValid   <= 1'b0;
      hazUnknown <= 1'b0;
      hazCycles  <= '0;
      hazReg     <= '0;
    end else if (strobe.loadKnown) begin
      hazValid   <= 1'b1;
      hazUnknown <= 1'b0;
      hazCycles  <= remFlat[sel*REM_W +: REM_W];
      hazReg     <= regId[sel*REG_W +: REG_W];
    end else if (strobe.loadUnknown) begin
      hazValid   <= 1'b1;
      hazUnknown <= 1'b1;
      hazCycles  <= '0;
      hazReg     <= regId[sel*REG_W +: REG_W];
    end else begin
      hazValid   <= 1'b0;
      hazUnknown <= 1'b0;
      hazCycles  <= '0;
      hazReg     <= '0;
    end
  end

  // R9: exactly one load decision per cycle
  p_strobe_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({strobe.loadKnown, strobe.loadUnknown, strobe.loadNone}));
  // R9: a "none" decision shows up after the edge
  p_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadNone |=> !hazValid);
  // R2: a known reported hazard is strictly positive
  p_known_positive_r2: assert property (@(posedge clk) disable iff (!rstN)
    (hazValid && !hazUnknown) |-> (hazCycles != '0));
  // R5: unknown hazards carry no cycle count
  p_unknown_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    hazUnknown |-> (hazValid && (hazCycles == '0)));
  // R6: with no hazard every output is cleared
  p_none_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    !hazValid |-> (!hazUnknown && (hazCycles == '0) && (hazReg == '0)));
endmodule

// File: rtl/hazControl.sv
module hazControl
  import hazEvalPkg::*;
#(
  parameter int N     = 4,
  parameter int CYC_W = 8
) (
  input  logic [N-1:0]           inFlight,
  input  logic [N-1:0]           knownCand,
  input  logic [N-1:0]           unkCand,
  input  logic [N*(CYC_W+1)-1:0] remFlat,
  output hazStrobe_t             strobe
);
  localparam int REM_W = CYC_W + 1;

  logic             found;
  logic [REM_W-1:0] bestVal;
  logic [SEL_W-1:0] bestIdx;
  logic             anyUnk;
  logic [SEL_W-1:0] unkIdx;

  // Pass 0 scans in-flight entries, pass 1 completed ones; strict compare
  // keeps the earliest entry on a tie.
  always_comb begin
    found   = 1'b0;
    bestVal = '0;
    bestIdx = '0;
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < N; i++) begin
        if (knownCand[i] && (inFlight[i] == (p == 0)) &&
            (!found || (remFlat[i*REM_W +: REM_W] > bestVal))) begin
          found   = 1'b1;
          bestVal = remFlat[i*REM_W +: REM_W];
          bestIdx = SEL_W'(i);
        end
      end
    end
  end

  always_comb begin
    anyUnk = 1'b0;
    unkIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (unkCand[i]) begin
        anyUnk = 1'b1;
        unkIdx = SEL_W'(i);
      end
    end
  end

  always_comb begin
    strobe.loadKnown   = found;
    strobe.loadUnknown = !found && anyUnk;
    strobe.loadNone    = !found && !anyUnk;
    strobe.selIdx      = found ? bestIdx : unkIdx;
  end
endmodule

// File: rtl/readHazardEval.sv
module readHazardEval
  import hazEvalPkg::*;
#(
  parameter int N     = 4,
  parameter int CYC_W = 8,
  parameter int ADV_W = 4,
  parameter int REG_W = 6,
  parameter int PID_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CYC_W-1:0]   curCycle,
  input  logic [N-1:0]       entValid,
  input  logic [N-1:0]       inFlight,
  input  logic [N-1:0]       latUnknown,
  input  logic [N*CYC_W-1:0] cyclesLeft,
  input  logic [N*CYC_W-1:0] wbCycle,
  input  logic [N*ADV_W-1:0] readAdv,
  input  logic [N*REG_W-1:0] regId,
  input  logic [N*PID_W-1:0] prodId,
  output logic               hazValid,
  output logic               hazUnknown,
  output logic [CYC_W:0]     hazCycles,
  output logic [REG_W-1:0]   hazReg
);
  localparam int REM_W = CYC_W + 1;

  hazStrobe_t           strobe;
  logic [N-1:0]         knownCand;
  logic [N-1:0]         unkCand;
  logic [N*REM_W-1:0]   remFlat;

  hazDatapath #(.N(N), .CYC_W(CYC_W), .ADV_W(ADV_W), .REG_W(REG_W), .PID_W(PID_W)) u_datapath (
    .clk(clk), .rstN(rstN), .curCycle(curCycle), .entValid(entValid),
    .inFlight(inFlight), .latUnknown(latUnknown), .cyclesLeft(cyclesLeft),
    .wbCycle(wbCycle), .readAdv(readAdv), .regId(regId), .prodId(prodId),
    .strobe(strobe), .knownCand(knownCand), .unkCand(unkCand), .remFlat(remFlat),
    .hazValid(hazValid), .hazUnknown(hazUnknown), .hazCycles(hazCycles), .hazReg(hazReg)
  );

  hazControl #(.N(N), .CYC_W(CYC_W)) u_control (
    .inFlight(inFlight), .knownCand(knownCand), .unkCand(unkCand),
    .remFlat(remFlat), .strobe(strobe)
  );
endmodule

// File: tb/test_readHazardEval.sv
module test_readHazardEval;
  localparam int N = 4, CYC_W = 8, ADV_W = 4, REG_W = 6, PID_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CYC_W-1:0]   curCycle = '0;
  logic [N-1:0]       entValid = '0, inFlight = '0, latUnknown = '0;
  logic [N*CYC_W-1:0] cyclesLeft = '0, wbCycle = '0;
  logic [N*ADV_W-1:0] readAdv = '0;
  logic [N*REG_W-1:0] regId = '0;
  logic [N*PID_W-1:0] prodId = '0;
  logic               hazValid, hazUnknown;
  logic [CYC_W:0]     hazCycles;
  logic [REG_W-1:0]   hazReg;

  int nChecks = 0, nFails = 0;
  int ev[N], fl[N], lu[N], cl[N], wb[N], adv[N], rg[N], pd[N];
  int cur;
  int expV, expU, expC, expR;

  always #4 clk = ~clk;

  readHazardEval #(.N(N), .CYC_W(CYC_W), .ADV_W(ADV_W), .REG_W(REG_W), .PID_W(PID_W)) i_readHazardEval (
    .clk(clk), .rstN(rstN), .curCycle(curCycle), .entValid(entValid),
    .inFlight(inFlight), .latUnknown(latUnknown), .cyclesLeft(cyclesLeft),
    .wbCycle(wbCycle), .readAdv(readAdv), .regId(regId), .prodId(prodId),
    .hazValid(hazValid), .hazUnknown(hazUnknown), .hazCycles(hazCycles), .hazReg(hazReg)
  );

  task automatic clearEntries();
    for (int i = 0; i < N; i++) begin
      ev[i] = 0; fl[i] = 0; lu[i] = 0; cl[i] = 0; wb[i] = 0; adv[i] = 0; rg[i] = 0; pd[i] = i;
    end
    cur = 0;
  endtask

  task automatic setEnt(int i, int f, int u, int c, int w, int a, int r, int p);
    ev[i] = 1; fl[i] = f; lu[i] = u; cl[i] = c; wb[i] = w; adv[i] = a; rg[i] = r; pd[i] = p;
  endtask

  task automatic driveEntries();
    curCycle = CYC_W'(cur);
    for (int i = 0; i < N; i++) begin
      entValid[i]   = ev[i][0];
      inFlight[i]   = fl[i][0];
      latUnknown[i] = lu[i][0];
      cyclesLeft[i*CYC_W +: CYC_W] = CYC_W'(cl[i]);
      wbCycle[i*CYC_W +: CYC_W]    = CYC_W'(wb[i]);
      readAdv[i*ADV_W +: ADV_W]    = ADV_W'(adv[i]);
      regId[i*REG_W +: REG_W]      = REG_W'(rg[i]);
      prodId[i*PID_W +: PID_W]     = PID_W'(pd[i]);
    end
  endtask

  // Reference model built from the requirements
  task automatic computeExpected();
    int val[N];
    int best;
    bit elig;
    best = 0;
    for (int i = 0; i < N; i++) begin
      val[i] = 0;
      elig = (ev[i] != 0);
      for (int j = 0; j < i; j++) if (ev[j] != 0 && pd[j] == pd[i]) elig = 0;
      if (elig) begin
        if (fl[i] != 0) begin
          if (lu[i] == 0 && cl[i] - adv[i] > 0) val[i] = cl[i] - adv[i];
        end else if (adv[i] < 0) begin
          int el;
          el = (cur - wb[i]) & ((1 << CYC_W) - 1);
          if (el < -adv[i]) val[i] = -adv[i] - el;
        end
      end else val[i] = -1;
      if (val[i] > best) best = val[i];
    end
    expV = 0; expU = 0; expC = 0; expR = 0;
    if (best > 0) begin
      expV = 1; expC = best;
      for (int k = 2 * N - 1; k >= 0; k--) begin
        int i;
        i = k % N;
        if ((fl[i] != 0) == (k < N) && val[i] == best) expR = rg[i];
      end
    end else begin
      for (int i = N - 1; i >= 0; i--) begin
        if (val[i] >= 0 && fl[i] != 0 && lu[i] != 0) begin
          expV = 1; expU = 1; expR = rg[i];
        end
      end
    end
  endtask

  task automatic compareOut(string tag, int v, int u, int c, int r);
    nChecks++;
    if (hazValid !== v[0] || hazUnknown !== u[0] || hazCycles !== (CYC_W+1)'(c) ||
        hazReg !== REG_W'(r)) begin
      nFails++;
      $display("FAIL %s: got valid=%0d unk=%0d cyc=%0d reg=%0d, expected valid=%0d unk=%0d cyc=%0d reg=%0d",
               tag, hazValid, hazUnknown, hazCycles, hazReg, v, u, c, r);
    end
  endtask

  task automatic runCase(string tag);
    driveEntries();
    computeExpected();
    @(negedge clk);
    compareOut(tag, expV, expU, expC, expR);
  endtask

  initial begin
    clearEntries();
    driveEntries();
    #20;
    compareOut("R1 reset", 0, 0, 0, 0);
    @(negedge clk);
    rstN = 1'b1;
    compareOut("R1 after release", 0, 0, 0, 0);

    clearEntries(); setEnt(0, 1, 0, 5, 0, 2, 7, 1);           runCase("R2 basic");
    clearEntries(); setEnt(1, 1, 0, 2, 0, 3, 9, 1);           runCase("R2 nonpositive R6");
    clearEntries(); setEnt(2, 1, 0, 3, 0, 3, 9, 1);           runCase("R2 zero");
    clearEntries(); setEnt(0, 1, 0, 3, 0, -4, 11, 1);         runCase("R2 negative advance");
    clearEntries(); setEnt(3, 1, 0, 255, 0, -8, 12, 1);       runCase("R2 max range");
    clearEntries(); cur = 20; setEnt(0, 0, 0, 0, 18, -5, 4, 1); runCase("R3 completed");
    clearEntries(); cur = 20; setEnt(0, 0, 0, 0, 18, -2, 4, 1); runCase("R3 elapsed equal");
    clearEntries(); cur = 1;  setEnt(1, 0, 0, 0, 254, -8, 5, 1); runCase("R3 wrap");
    clearEntries(); cur = 5;  setEnt(1, 0, 0, 0, 5, 3, 5, 1);  runCase("R3 positive advance");
    clearEntries(); setEnt(0, 1, 0, 4, 0, 0, 1, 1); cur = 10;
      setEnt(1, 0, 0, 0, 8, -8, 2, 2); setEnt(2, 1, 0, 6, 0, 0, 3, 3); runCase("R4 tie order");
    clearEntries(); setEnt(0, 1, 0, 2, 0, 0, 1, 1); setEnt(3, 1, 0, 9, 0, 1, 8, 3); runCase("R4 max");
    clearEntries(); setEnt(2, 1, 1, 0, 0, 0, 21, 1);          runCase("R5 unknown only");
    clearEntries(); setEnt(0, 1, 1, 0, 0, 0, 21, 1); setEnt(1, 1, 0, 4, 0, 1, 22, 2); runCase("R5 known overrides");
    clearEntries(); setEnt(1, 1, 1, 0, 0, 0, 30, 1); setEnt(3, 1, 1, 0, 0, 0, 31, 2); runCase("R5 first unknown");
    clearEntries(); cur = 7; setEnt(0, 1, 1, 0, 0, 0, 30, 1); setEnt(2, 0, 0, 0, 6, -3, 33, 2); runCase("R5 completed overrides");
    clearEntries(); setEnt(0, 1, 0, 2, 0, 0, 13, 3); setEnt(1, 1, 0, 9, 0, 0, 14, 3); runCase("R7 duplicate");
    clearEntries(); setEnt(0, 1, 0, 2, 0, 0, 13, 3); setEnt(2, 1, 1, 0, 0, 0, 14, 3); runCase("R7 duplicate unknown");
    clearEntries(); setEnt(1, 1, 0, 200, 0, 0, 15, 1); ev[1] = 0; setEnt(2, 1, 0, 3, 0, 0, 16, 2); runCase("R8 invalid");
    clearEntries(); setEnt(0, 1, 0, 50, 0, 0, 17, 1); ev[0] = 0; setEnt(1, 1, 0, 3, 0, 0, 16, 1); runCase("R8 invalid no dedup");

    // R9: output held until the next rising edge
    clearEntries(); setEnt(0, 1, 0, 6, 0, 0, 40, 1); runCase("R9 setup");
    clearEntries(); setEnt(0, 1, 0, 9, 0, 0, 41, 1); driveEntries();
    #1 compareOut("R9 held before edge", 1, 0, 6, 40);
    @(negedge clk); compareOut("R9 after edge", 1, 0, 9, 41);

    void'($urandom(1234));
    for (int t = 0; t < 400; t++) begin
      clearEntries();
      cur = $urandom_range(0, 255);
      for (int i = 0; i < N; i++) begin
        int a;
        ev[i] = ($urandom_range(0, 4) != 0);
        fl[i] = $urandom_range(0, 1);
        lu[i] = ($urandom_range(0, 5) == 0);
        cl[i] = $urandom_range(0, 12);
        wb[i] = (cur - $urandom_range(0, 10)) & 255;
        a = $urandom_range(0, 15);
        adv[i] = (a >= 8) ? a - 16 : a;
        rg[i] = $urandom_range(1, 63);
        pd[i] = $urandom_range(0, 5);
      end
      runCase("R4 random");
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog R9: got timeout, expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule